// File: doc/BRIEF.md
# Flash Transfer Chunking Sequencer

This block sits between a requester and a serial-flash command engine. It accepts one flash operation at a time and turns it into a series of engine transactions. Each transaction holds an opcode, an optional 3-byte address and at most four data bytes. The opcode tells the block how many address, send and receive bytes the operation needs. Long reads and page programs are cut into pieces. After each piece the address moves forward by the number of data bytes that piece carried.

Program operations take extra steps around every piece. A write-enable command goes out before each piece. After each piece the block polls the status register until the busy bit drops. A fast read is sent to the engine as a plain read, and its dummy byte is dropped. Write data comes in on a byte stream with a valid/ready handshake. Read data leaves on a byte stream that carries only a valid strobe. A one-cycle done pulse with an error flag closes every request.

Top module: `flash_chunk_seq`

## Requirements
- R1: After reset, req_ready is 1 and done_o, err_o, eng_start, wr_ready and rd_valid are all 0.
- R2: Opcodes 0x06, 0x04 and 0xC7 each produce exactly one engine transaction, with address count 0, send count 0 and receive count 0. The length inputs are ignored and no write-stream byte is consumed. The request then ends with done_o and err_o = 0.
- R3: The following opcodes use fixed byte counts and ignore the length inputs:
  - 0x9F receives 3 bytes.
  - 0x05 receives 1 byte.
  - 0x01 sends 1 byte taken from the write stream.
  - 0xAB sends address count 3 with address 0, then receives 1 byte.
  - 0xD8 sends address count 3 with the request address.
- R4: Opcode 0x0B takes one byte from the write stream and discards it. Every transaction it causes carries opcode 0x03; 0x0B never reaches the engine.
- R5: Opcodes 0x03, 0x0B and 0x02 send address count 3. Their data is split into pieces of at most 4 bytes. Each piece's address is the previous piece's address plus the number of bytes that piece moved.
- R6: Send bytes are packed in arrival order into eng_tx_data. Byte i sits at bits 8i+7:8i, and unused lanes are 0. Received bytes leave on rd_byte one per cycle, lowest lane first. The write stream and the read stream are never active in the same cycle.
- R7: For opcode 0x02, a 0x06 transaction comes before each data piece. After each piece, status reads follow: opcode 0x05, address count 0, send count 0, receive count 1. These repeat while eng_rx_data bit 0 is 1. The request finishes after the first clear status that follows the last piece.
- R8: If POLL_LIMIT status reads in a row return busy, polling stops and the request ends with err_o = 1.
- R9: An opcode outside R2–R5, or a request with both req_wlen and req_rlen nonzero, starts no transaction and consumes no write byte. It raises done_o with err_o = 1 in the cycle right after acceptance.
- R10: req_ready is 1 only while the block is idle, and done_o is high for exactly one cycle.
- R11: A read with zero length still issues one piece with receive count 0. A non-program request finishes after the piece that leaves nothing remaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_opcode | input | 8 | Flash opcode |
| req_addr | input | ADDR_W | Start address |
| req_wlen | input | LEN_W | Bytes to send (variable-length opcodes) |
| req_rlen | input | LEN_W | Bytes to receive (variable-length opcodes) |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request failed, valid with done_o |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_byte | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_byte | output | 8 | Read byte |
| eng_start | output | 1 | Start one engine transaction |
| eng_opcode | output | 8 | Transaction opcode |
| eng_addr | output | ADDR_W | Transaction address |
| eng_addr_cnt | output | 2 | Address bytes (0 or 3) |
| eng_tx_cnt | output | CNT_W | Data bytes to send |
| eng_tx_data | output | DATA_W | Send bytes, lane 0 first |
| eng_rx_cnt | output | CNT_W | Data bytes to receive |
| eng_done | input | 1 | Engine finished transaction |
| eng_rx_data | input | DATA_W | Received bytes, lane 0 first |

## Verification
A rejected request has its done_o pulse due on the first falling edge after the accepting clock edge, and the bench checks it there with a wait count of zero. Every other result comes after a variable number of engine round trips. For those, each task polls done_o on falling edges with a bounded loop and then checks that done_o is low again one cycle later. The bench engine model returns eng_done two cycles after it sees eng_start. Transaction fields are logged on the falling edge in which eng_start is high, and read bytes are logged on every falling edge with rd_valid high. All comparisons use these logs and are made only after done_o, so a piece that comes one cycle later still compares equal in order and content.

// File: rtl/fcs_pkg.sv
// Shared opcodes and state encodings for the flash chunking sequencer.
package fcs_pkg;
    localparam logic [7:0] OP_WREN         = 8'h06;
    localparam logic [7:0] OP_WRDI         = 8'h04;
    localparam logic [7:0] OP_CHIP_ERASE   = 8'hC7;
    localparam logic [7:0] OP_JEDEC_ID     = 8'h9F;
    localparam logic [7:0] OP_RD_STATUS    = 8'h05;
    localparam logic [7:0] OP_WR_STATUS    = 8'h01;
    localparam logic [7:0] OP_LEGACY_ID    = 8'hAB;
    localparam logic [7:0] OP_SECTOR_ERASE = 8'hD8;
    localparam logic [7:0] OP_READ         = 8'h03;
    localparam logic [7:0] OP_FAST_READ    = 8'h0B;
    localparam logic [7:0] OP_PROGRAM      = 8'h02;

    localparam int STATUS_BUSY_BIT = 0;

    typedef enum logic [2:0] {
        S_IDLE, S_DUMMY, S_LOAD, S_ISSUE, S_WAIT, S_DRAIN
    } seq_state_t;

    typedef enum logic [1:0] {
        K_PIECE, K_WREN, K_POLL
    } xfer_kind_t;
endpackage

// File: rtl/fcs_decode.sv
// Opcode decoder: maps an opcode and the requested lengths to the
// byte counts of the whole operation and flags illegal requests.
// Assumes the lengths matter only for the variable-length opcodes.
module fcs_decode
    import fcs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [7:0]       op_i,
    input  logic [LEN_W-1:0] wlen_i,
    input  logic [LEN_W-1:0] rlen_i,
    output logic             legal_o,
    output logic             prog_o,
    output logic             fast_o,
    output logic             has_addr_o,
    output logic             zero_addr_o,
    output logic [7:0]       send_op_o,
    output logic [LEN_W-1:0] tot_w_o,
    output logic [LEN_W-1:0] tot_r_o
);
    logic known;

    // Table lookup of per-opcode byte counts.
    always_comb begin
        known       = 1'b1;
        prog_o      = 1'b0;
        fast_o      = 1'b0;
        has_addr_o  = 1'b0;
        zero_addr_o = 1'b0;
        send_op_o   = op_i;
        tot_w_o     = '0;
        tot_r_o     = '0;
        case (op_i)
            OP_WREN, OP_WRDI, OP_CHIP_ERASE: begin
            end
            OP_JEDEC_ID:  tot_r_o = LEN_W'(3);
            OP_RD_STATUS: tot_r_o = LEN_W'(1);
            OP_WR_STATUS: tot_w_o = LEN_W'(1);
            OP_LEGACY_ID: begin
                has_addr_o  = 1'b1;
                zero_addr_o = 1'b1;
                tot_r_o     = LEN_W'(1);
            end
            OP_SECTOR_ERASE: has_addr_o = 1'b1;
            OP_READ: begin
                has_addr_o = 1'b1;
                tot_w_o    = wlen_i;
                tot_r_o    = rlen_i;
            end
            OP_FAST_READ: begin
                has_addr_o = 1'b1;
                fast_o     = 1'b1;
                send_op_o  = OP_READ;
                tot_w_o    = wlen_i;
                tot_r_o    = rlen_i;
            end
            OP_PROGRAM: begin
                has_addr_o = 1'b1;
                prog_o     = 1'b1;
                tot_w_o    = wlen_i;
                tot_r_o    = rlen_i;
            end
            default: known = 1'b0;
        endcase
        legal_o = known && !((tot_w_o != '0) && (tot_r_o != '0));
    end
endmodule

// File: rtl/fcs_tx_pack.sv
// Send-byte packer: collects write-stream bytes into lanes, first byte
// in lane 0. Assumes take is only raised while a lane is still free.
module fcs_tx_pack #(
    parameter int MAX_PIECE = 4,
    localparam int DATA_W = 8 * MAX_PIECE,
    localparam int CNT_W  = $clog2(MAX_PIECE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        byte_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [MAX_PIECE-1:0][7:0] lane_q;
    logic [CNT_W-1:0]          cnt_q;

    // Place each taken byte in the next free lane.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lane_q <= '0;
            cnt_q  <= '0;
        end else if (take) begin
            for (int i = 0; i < MAX_PIECE; i++) begin
                if (cnt_q == CNT_W'(i)) lane_q[i] <= byte_i;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign data_o = lane_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/fcs_rx_drain.sv
// Receive drain: holds the bytes of one finished piece and emits them
// one per cycle, lane 0 first. Assumes load only when empty.
module fcs_rx_drain #(
    parameter int MAX_PIECE = 4,
    localparam int DATA_W = 8 * MAX_PIECE,
    localparam int CNT_W  = $clog2(MAX_PIECE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              valid_o,
    output logic [7:0]        byte_o,
    output logic              empty_o
);
    logic [DATA_W-1:0] buf_q;
    logic [CNT_W-1:0]  cnt_q;

    // Load a piece, then shift one byte out per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            buf_q <= data_i;
            cnt_q <= cnt_i;
        end else if (cnt_q != '0) begin
            buf_q <= {8'h00, buf_q[DATA_W-1:8]};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign valid_o = (cnt_q != '0);
    assign byte_o  = buf_q[7:0];
    assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/flash_chunk_seq.sv
// Flash chunking sequencer: runs one flash operation as a series of
// engine transactions of at most MAX_PIECE data bytes. Program pieces
// are wrapped in write-enable and busy polling. Assumes the engine
// answers every eng_start with exactly one eng_done pulse.
module flash_chunk_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int MAX_PIECE  = 4,
    parameter int POLL_LIMIT = 1024,
    localparam int DATA_W = 8 * MAX_PIECE,
    localparam int CNT_W  = $clog2(MAX_PIECE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_wlen,
    input  logic [LEN_W-1:0]  req_rlen,
    output logic              done_o,
    output logic              err_o,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_byte,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              eng_start,
    output logic [7:0]        eng_opcode,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [1:0]        eng_addr_cnt,
    output logic [CNT_W-1:0]  eng_tx_cnt,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic [CNT_W-1:0]  eng_rx_cnt,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_data
);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    seq_state_t        state_q;
    xfer_kind_t        kind_q;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        acnt_q;
    logic              prog_q;
    logic [LEN_W-1:0]  wrem_q;
    logic [LEN_W-1:0]  rrem_q;
    logic [POLL_W-1:0] poll_q;
    logic              done_q;
    logic              err_q;

    logic              dec_legal, dec_prog, dec_fast, dec_has_addr, dec_zero_addr;
    logic [7:0]        dec_op;
    logic [LEN_W-1:0]  dec_w, dec_r;
    logic [CNT_W-1:0]  piece_tx, piece_rx;
    logic [DATA_W-1:0] pk_data;
    logic [CNT_W-1:0]  pk_cnt;
    logic              pk_take, pk_clear;
    logic              dr_load, dr_empty;
    logic              status_busy;

    fcs_decode #(.LEN_W(LEN_W)) u_decode (
        .op_i        (req_opcode),
        .wlen_i      (req_wlen),
        .rlen_i      (req_rlen),
        .legal_o     (dec_legal),
        .prog_o      (dec_prog),
        .fast_o      (dec_fast),
        .has_addr_o  (dec_has_addr),
        .zero_addr_o (dec_zero_addr),
        .send_op_o   (dec_op),
        .tot_w_o     (dec_w),
        .tot_r_o     (dec_r)
    );

    // Size of the current piece from the bytes still owed.
    always_comb begin
        piece_tx = (wrem_q >= LEN_W'(MAX_PIECE)) ? CNT_W'(MAX_PIECE) : wrem_q[CNT_W-1:0];
        piece_rx = (rrem_q >= LEN_W'(MAX_PIECE)) ? CNT_W'(MAX_PIECE) : rrem_q[CNT_W-1:0];
    end

    assign wr_ready = (state_q == S_DUMMY) || ((state_q == S_LOAD) && (pk_cnt < piece_tx));
    assign pk_take  = (state_q == S_LOAD) && wr_valid && wr_ready;
    assign pk_clear = (state_q == S_ISSUE) || (state_q == S_IDLE);
    assign dr_load  = (state_q == S_WAIT) && eng_done && (kind_q == K_PIECE);
    assign status_busy = eng_rx_data[STATUS_BUSY_BIT];

    fcs_tx_pack #(.MAX_PIECE(MAX_PIECE)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pk_clear),
        .take   (pk_take),
        .byte_i (wr_byte),
        .data_o (pk_data),
        .cnt_o  (pk_cnt)
    );

    fcs_rx_drain #(.MAX_PIECE(MAX_PIECE)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dr_load),
        .data_i  (eng_rx_data),
        .cnt_i   (piece_rx),
        .valid_o (rd_valid),
        .byte_o  (rd_byte),
        .empty_o (dr_empty)
    );

    // Engine command fields chosen by the kind of transaction in flight.
    always_comb begin
        eng_start    = (state_q == S_ISSUE);
        eng_opcode   = op_q;
        eng_addr     = addr_q;
        eng_addr_cnt = acnt_q;
        eng_tx_cnt   = piece_tx;
        eng_tx_data  = pk_data;
        eng_rx_cnt   = piece_rx;
        if (kind_q == K_WREN) begin
            eng_opcode   = OP_WREN;
            eng_addr     = '0;
            eng_addr_cnt = 2'd0;
            eng_tx_cnt   = '0;
            eng_tx_data  = '0;
            eng_rx_cnt   = '0;
        end else if (kind_q == K_POLL) begin
            eng_opcode   = OP_RD_STATUS;
            eng_addr     = '0;
            eng_addr_cnt = 2'd0;
            eng_tx_cnt   = '0;
            eng_tx_data  = '0;
            eng_rx_cnt   = CNT_W'(1);
        end
    end

    // Main sequencing: accept, gather, issue, wait, drain, poll, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_PIECE;
            op_q    <= '0;
            addr_q  <= '0;
            acnt_q  <= '0;
            prog_q  <= 1'b0;
            wrem_q  <= '0;
            rrem_q  <= '0;
            poll_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        if (!dec_legal) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            op_q   <= dec_op;
                            addr_q <= dec_zero_addr ? '0 : req_addr;
                            acnt_q <= dec_has_addr ? 2'd3 : 2'd0;
                            prog_q <= dec_prog;
                            wrem_q <= dec_w;
                            rrem_q <= dec_r;
                            if (dec_fast) begin
                                state_q <= S_DUMMY;
                            end else if (dec_prog) begin
                                kind_q  <= K_WREN;
                                state_q <= S_ISSUE;
                            end else begin
                                state_q <= S_LOAD;
                            end
                        end
                    end
                end
                S_DUMMY: begin
                    if (wr_valid) state_q <= S_LOAD;
                end
                S_LOAD: begin
                    if (pk_cnt == piece_tx) begin
                        kind_q  <= K_PIECE;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (eng_done) begin
                        case (kind_q)
                            K_WREN: state_q <= S_LOAD;
                            K_POLL: begin
                                if (!status_busy) begin
                                    if (wrem_q == '0) begin
                                        done_q  <= 1'b1;
                                        state_q <= S_IDLE;
                                    end else begin
                                        kind_q  <= K_WREN;
                                        state_q <= S_ISSUE;
                                    end
                                end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
                                    done_q  <= 1'b1;
                                    err_q   <= 1'b1;
                                    state_q <= S_IDLE;
                                end else begin
                                    poll_q  <= poll_q + 1'b1;
                                    state_q <= S_ISSUE;
                                end
                            end
                            default: begin
                                wrem_q  <= wrem_q - LEN_W'(piece_tx);
                                rrem_q  <= rrem_q - LEN_W'(piece_rx);
                                addr_q  <= addr_q + ADDR_W'(piece_tx) + ADDR_W'(piece_rx);
                                state_q <= S_DRAIN;
                            end
                        endcase
                    end
                end
                S_DRAIN: begin
                    if (dr_empty) begin
                        if (prog_q) begin
                            poll_q  <= '0;
                            kind_q  <= K_POLL;
                            state_q <= S_ISSUE;
                        end else if ((wrem_q == '0) && (rrem_q == '0)) begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            state_q <= S_LOAD;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == S_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;
endmodule

// File: rtl/fcs_checks.sv
// Property checker for the flash chunking sequencer, bound to the top.
// Assumes a synchronous active-low reset driven low from time zero.
module fcs_checks #(
    parameter int MAX_PIECE = 4,
    localparam int CNT_W = $clog2(MAX_PIECE + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             done_o,
    input logic             err_o,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             eng_start,
    input logic [7:0]       eng_opcode,
    input logic [CNT_W-1:0] eng_tx_cnt,
    input logic [CNT_W-1:0] eng_rx_cnt
);
    AST_PIECE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_tx_cnt <= CNT_W'(MAX_PIECE) && eng_rx_cnt <= CNT_W'(MAX_PIECE))); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R5
    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_tx_cnt == '0 || eng_rx_cnt == '0)); // R9
    AST_NO_FAST_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_opcode != 8'h0B)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!eng_start && !wr_ready && !rd_valid)); // R10
    AST_STREAMS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && rd_valid)); // R6
endmodule

bind flash_chunk_seq fcs_checks #(.MAX_PIECE(MAX_PIECE)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done_o     (done_o),
    .err_o      (err_o),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .eng_start  (eng_start),
    .eng_opcode (eng_opcode),
    .eng_tx_cnt (eng_tx_cnt),
    .eng_rx_cnt (eng_rx_cnt)
);

// File: tb/flash_chunk_seq_test.sv
// Directed bench: an engine model answers each start after two cycles,
// a write-stream source feeds queued bytes, a sink logs read bytes.
module flash_chunk_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wlen = '0;
    logic [15:0] req_rlen = '0;
    logic        done_o, err_o;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_byte = '0;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        eng_start;
    logic [7:0]  eng_opcode;
    logic [23:0] eng_addr;
    logic [1:0]  eng_addr_cnt;
    logic [2:0]  eng_tx_cnt;
    logic [31:0] eng_tx_data;
    logic [2:0]  eng_rx_cnt;
    logic        eng_done = 1'b0;
    logic [31:0] eng_rx_data = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Transaction, read and write logs.
    logic [7:0]  lg_op [64];
    logic [23:0] lg_addr [64];
    logic [1:0]  lg_acnt [64];
    logic [2:0]  lg_tx [64];
    logic [2:0]  lg_rx [64];
    logic [31:0] lg_txd [64];
    int          lg_n = 0;
    logic [7:0]  rq [64];
    int          rq_n = 0;
    logic [7:0]  wq [64];
    int          wq_head = 0;
    int          wq_n = 0;
    logic        wtake = 1'b0;
    int          eng_cd = 0;
    logic [7:0]  rx_seq = 8'h20;
    int          busy_left = 0;
    logic        last_err;
    int          last_cyc;
    logic        rdy_mid;

    flash_chunk_seq #(.POLL_LIMIT(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_wlen(req_wlen), .req_rlen(req_rlen),
        .done_o(done_o), .err_o(err_o),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .eng_start(eng_start), .eng_opcode(eng_opcode), .eng_addr(eng_addr),
        .eng_addr_cnt(eng_addr_cnt), .eng_tx_cnt(eng_tx_cnt), .eng_tx_data(eng_tx_data),
        .eng_rx_cnt(eng_rx_cnt), .eng_done(eng_done), .eng_rx_data(eng_rx_data)
    );

    always #10 clk = ~clk;

    // Engine model: log each start, answer two cycles later.
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_cd > 0) begin
            eng_cd = eng_cd - 1;
            if (eng_cd == 0) eng_done = 1'b1;
        end
        if (eng_start) begin
            if (lg_n < 64) begin
                lg_op[lg_n] = eng_opcode; lg_addr[lg_n] = eng_addr;
                lg_acnt[lg_n] = eng_addr_cnt; lg_tx[lg_n] = eng_tx_cnt;
                lg_rx[lg_n] = eng_rx_cnt; lg_txd[lg_n] = eng_tx_data;
                lg_n = lg_n + 1;
            end
            eng_rx_data = '0;
            if (eng_opcode == 8'h05) begin
                eng_rx_data[0] = (busy_left > 0);
                if (busy_left > 0) busy_left = busy_left - 1;
            end else begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(eng_rx_cnt)) begin
                        eng_rx_data[8*k +: 8] = rx_seq;
                        rx_seq = rx_seq + 8'd1;
                    end
                end
            end
            eng_cd = 2;
        end
    end

    // Write-stream source and read-stream sink.
    always @(negedge clk) begin
        if (wtake) wq_head = wq_head + 1;
        wr_valid = (wq_head < wq_n);
        wr_byte  = wq[wq_head % 64];
        wtake    = wr_valid && wr_ready;
        if (rd_valid && rq_n < 64) begin
            rq[rq_n] = rd_byte;
            rq_n = rq_n + 1;
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        wq[wq_n % 64] = b;
        wq_n = wq_n + 1;
    endtask

    task automatic run_op(input logic [7:0] op, input logic [23:0] a,
                          input logic [15:0] wl, input logic [15:0] rl);
        int i;
        @(negedge clk);
        lg_n = 0; rq_n = 0;
        req_valid = 1'b1; req_opcode = op; req_addr = a; req_wlen = wl; req_rlen = rl;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_mid = req_ready;
        i = 0;
        while (!done_o && i < 5000) begin
            @(negedge clk);
            i++;
        end
        chk("R10", "done reached", done_o, 1'b1);
        last_err = err_o;
        last_cyc = i;
        @(negedge clk);
        chk("R10", "done one-cycle pulse", done_o, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "req_ready", req_ready, 1'b1);
        chk("R1", "done_o", done_o, 1'b0);
        chk("R1", "err_o", err_o, 1'b0);
        chk("R1", "eng_start", eng_start, 1'b0);
        chk("R1", "wr_ready", wr_ready, 1'b0);
        chk("R1", "rd_valid", rd_valid, 1'b0);
    endtask

    task automatic t_opcode_only;
        logic [7:0] ops [3] = '{8'h06, 8'h04, 8'hC7};
        for (int j = 0; j < 3; j++) begin
            int h0;
            push(8'h99);
            h0 = wq_head;
            run_op(ops[j], 24'h001234, 16'd3, 16'd0);
            chk("R2", "count", lg_n, 1);
            chk("R2", "opcode", lg_op[0], ops[j]);
            chk("R2", "acnt/tx/rx", {lg_acnt[0], lg_tx[0], lg_rx[0]}, 0);
            chk("R2", "no write consumed", wq_head, h0);
            chk("R2", "err", last_err, 1'b0);
        end
        wq_head = wq_n;
    endtask

    task automatic t_fixed;
        logic [7:0] s0;
        int h0;
        s0 = rx_seq;
        run_op(8'h9F, 24'h000000, 16'd0, 16'd9);
        chk("R3", "jedec rx", lg_rx[0], 3);
        chk("R3", "jedec bytes out", rq_n, 3);
        for (int k = 0; k < 3; k++) chk("R6", "jedec order", rq[k], 8'(s0 + 8'(k)));
        run_op(8'h05, 24'h000000, 16'd0, 16'd0);
        chk("R3", "status rx", lg_rx[0], 1);
        chk("R3", "status byte", rq[0], 8'h00);
        run_op(8'hAB, 24'h123456, 16'd0, 16'd0);
        chk("R3", "legacy id acnt", lg_acnt[0], 3);
        chk("R3", "legacy id addr", lg_addr[0], 0);
        chk("R3", "legacy id rx", lg_rx[0], 1);
        h0 = wq_head;
        push(8'h5A);
        run_op(8'h01, 24'h000000, 16'd0, 16'd0);
        chk("R3", "wr status tx", lg_tx[0], 1);
        chk("R3", "wr status data", lg_txd[0], 32'h0000005A);
        chk("R3", "wr status consumed", wq_head, h0 + 1);
        run_op(8'hD8, 24'h0ABCDE, 16'd0, 16'd0);
        chk("R3", "erase acnt", lg_acnt[0], 3);
        chk("R3", "erase addr", lg_addr[0], 24'h0ABCDE);
        chk("R3", "erase tx/rx", {lg_tx[0], lg_rx[0]}, 0);
    endtask

    task automatic t_fast;
        logic [7:0] s0;
        int h0;
        h0 = wq_head;
        s0 = rx_seq;
        push(8'hEE);
        run_op(8'h0B, 24'h000010, 16'd0, 16'd5);
        chk("R4", "pieces", lg_n, 2);
        chk("R4", "op piece0", lg_op[0], 8'h03);
        chk("R4", "op piece1", lg_op[1], 8'h03);
        chk("R4", "dummy consumed", wq_head, h0 + 1);
        chk("R5", "fast addr1", lg_addr[1], 24'h000014);
        chk("R5", "fast rx1", lg_rx[1], 1);
        chk("R4", "bytes out", rq_n, 5);
        chk("R6", "fast last byte", rq[4], 8'(s0 + 8'd4));
    endtask

    task automatic t_read_chunks;
        logic [7:0] s0;
        s0 = rx_seq;
        run_op(8'h03, 24'h0100FE, 16'd0, 16'd10);
        chk("R10", "ready low while busy", rdy_mid, 1'b0);
        chk("R5", "pieces", lg_n, 3);
        chk("R5", "addr0", lg_addr[0], 24'h0100FE);
        chk("R5", "addr1", lg_addr[1], 24'h010102);
        chk("R5", "addr2", lg_addr[2], 24'h010106);
        chk("R5", "rx counts", {lg_rx[0], lg_rx[1], lg_rx[2]}, {3'd4, 3'd4, 3'd2});
        chk("R5", "acnt", lg_acnt[2], 3);
        chk("R11", "finish ok", last_err, 1'b0);
        chk("R6", "bytes out", rq_n, 10);
        for (int k = 0; k < 10; k++) chk("R6", "read order", rq[k], 8'(s0 + 8'(k)));
    endtask

    task automatic t_program;
        logic [7:0] exp_op [8] = '{8'h06, 8'h02, 8'h05, 8'h05, 8'h05, 8'h06, 8'h02, 8'h05};
        for (int k = 0; k < 6; k++) push(8'(8'h11 * (k + 1)));
        busy_left = 2;
        run_op(8'h02, 24'h002000, 16'd6, 16'd0);
        chk("R7", "count", lg_n, 8);
        for (int k = 0; k < 8; k++) chk("R7", "sequence", lg_op[k], exp_op[k]);
        chk("R7", "poll shape", {lg_acnt[2], lg_tx[2], lg_rx[2]}, {2'd0, 3'd0, 3'd1});
        chk("R6", "piece0 data", lg_txd[1], 32'h44332211);
        chk("R6", "piece1 data", lg_txd[6], 32'h00006655);
        chk("R5", "piece addrs", {lg_addr[1], lg_addr[6]}, {24'h002000, 24'h002004});
        chk("R5", "piece tx", {lg_tx[1], lg_tx[6]}, {3'd4, 3'd2});
        chk("R7", "err", last_err, 1'b0);
    endtask

    task automatic t_timeout;
        push(8'hA1);
        push(8'hA2);
        busy_left = 100;
        run_op(8'h02, 24'h003000, 16'd2, 16'd0);
        chk("R8", "count", lg_n, 6);
        chk("R8", "last is status", lg_op[5], 8'h05);
        chk("R8", "err", last_err, 1'b1);
        busy_left = 0;
    endtask

    task automatic t_reject;
        int h0;
        run_op(8'h55, 24'h000000, 16'd0, 16'd0);
        chk("R9", "unknown err", last_err, 1'b1);
        chk("R9", "unknown no txn", lg_n, 0);
        chk("R9", "done next cycle", last_cyc, 0);
        push(8'h77);
        h0 = wq_head;
        run_op(8'h03, 24'h000000, 16'd1, 16'd1);
        chk("R9", "duplex err", last_err, 1'b1);
        chk("R9", "duplex no txn", lg_n, 0);
        chk("R9", "no write consumed", wq_head, h0);
        wq_head = wq_n;
    endtask

    task automatic t_zero;
        run_op(8'h03, 24'h000400, 16'd0, 16'd0);
        chk("R11", "one piece", lg_n, 1);
        chk("R11", "counts", {lg_acnt[0], lg_tx[0], lg_rx[0]}, {2'd3, 3'd0, 3'd0});
        chk("R11", "err", last_err, 1'b0);
        run_op(8'h03, 24'h000400, 16'd0, 16'd4);
        chk("R11", "exact four one piece", lg_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_opcode_only();
        t_fixed();
        t_fast();
        t_read_chunks();
        t_program();
        t_timeout();
        t_reject();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule